// File: doc/BRIEF.md
# Multi-function ripple ALU

This block is a combinational arithmetic-logic unit of configurable width, assembled from identical one-bit slices. Every slice forms four candidate results side by side (bitwise AND, bitwise OR, bitwise XOR and the full-adder sum bit). A small four-way selector in the slice then picks one of them, steered by a two-bit operation code that all slices share.

Each slice also produces a carry as the majority of its two operand bits and its incoming carry. That carry feeds the next slice up, and the lowest slice takes the external carry-in. The carry leaving the top slice is presented as the carry-out for every operation code, so the adder chain is always active and only the result selection depends on the code. The block has no clock and no state. A datapath places it between operand registers and a result register.

Top module: `ripple_alu`

## Requirements
- R1: With op code 2'b00 the result equals the bitwise AND of a and b.
- R2: With op code 2'b01 the result equals the bitwise OR of a and b.
- R3: With op code 2'b10 the result equals the bitwise XOR of a and b.
- R4: With op code 2'b11 the result equals (a + b + carry_in) truncated to WIDTH bits.
- R5: For every op code, carry_out equals bit WIDTH of the unsigned sum a + b + carry_in.
- R6: The carry ripples through all slices. With a all ones, b zero and carry_in 1, op 2'b11 gives result zero and carry_out 1.
- R7: For op codes 2'b00, 2'b01 and 2'b10, the value of carry_in has no effect on the result.
- R8: In a single slice with a=1, b=1 and carry_in=0, op 2'b00 gives 1, op 2'b10 gives 0, and op 2'b11 gives 0 with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the lowest slice |
| op | input | 2 | Operation code: 00 AND, 01 OR, 10 XOR, 11 sum |
| result | output | WIDTH | Selected per-bit result |
| carry_out | output | 1 | Carry leaving the highest slice |

## Verification
The assertions compare whole-word results against word-level arithmetic and logic. They assume that a, b, carry_in and op are all driven to known values, and they skip evaluation while any input is unknown. The stimulus sets every input together in one step away from the bench clock edge. It reads the outputs only after the combinational settling time, so every evaluation sees a complete and consistent operand set.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_XOR = 2'b10,
        OP_SUM = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic sum_c;
        logic xor_c;
        logic or_c;
        logic and_c;
    } slice_cand_t;

    function automatic logic majority3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/alu_pick4.sv
module alu_pick4
    import ripple_alu_pkg::*;
(
    input  slice_cand_t cand,
    input  alu_op_e     sel,
    output logic        pick
);
    always_comb begin
        case (sel)
            OP_AND: pick = cand.and_c;
            OP_OR:  pick = cand.or_c;
            OP_XOR: pick = cand.xor_c;
            OP_SUM: pick = cand.sum_c;
        endcase
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import ripple_alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    c_in,
    input  alu_op_e sel,
    output logic    r_bit,
    output logic    c_out
);
    slice_cand_t cand;

    always_comb begin
        cand.and_c = a_bit & b_bit;
        cand.or_c  = a_bit | b_bit;
        cand.xor_c = a_bit ^ b_bit;
        cand.sum_c = a_bit ^ b_bit ^ c_in;
    end

    assign c_out = majority3(a_bit, b_bit, c_in);

    alu_pick4 pick_i (
        .cand (cand),
        .sel  (sel),
        .pick (r_bit)
    );
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ripple_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int CHAIN_LEN = WIDTH + 1;

    logic [CHAIN_LEN-1:0] chain;
    alu_op_e              op_sel;

    assign op_sel   = alu_op_e'(op);
    assign chain[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice slice_i (
            .a_bit (a[i]),
            .b_bit (b[i]),
            .c_in  (chain[i]),
            .sel   (op_sel),
            .r_bit (result[i]),
            .c_out (chain[i+1])
        );
    end

    assign carry_out = chain[WIDTH];
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             carry_in,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    logic [WIDTH:0] word_sum;
    assign word_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in};

    always_comb begin
        if (!$isunknown({a, b, carry_in, op, result, carry_out})) begin
            // R1
            and_op_chk: assert (op != 2'b00 || result == (a & b));
            // R2
            or_op_chk: assert (op != 2'b01 || result == (a | b));
            // R3
            xor_op_chk: assert (op != 2'b10 || result == (a ^ b));
            // R4
            sum_op_chk: assert (op != 2'b11 || result == word_sum[WIDTH-1:0]);
            // R5
            carry_out_chk: assert (carry_out == word_sum[WIDTH]);
        end
    end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .a         (a),
    .b         (b),
    .carry_in  (carry_in),
    .op        (op),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/ripple_alu_tb_top.sv
module ripple_alu_tb_top;
    localparam int WIDTH = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] a = '0;
    logic [WIDTH-1:0] b = '0;
    logic             carry_in = 1'b0;
    logic [1:0]       op = 2'b00;
    logic [WIDTH-1:0] result;
    logic             carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ripple_alu #(.WIDTH(WIDTH)) dut_i (
        .a         (a),
        .b         (b),
        .carry_in  (carry_in),
        .op        (op),
        .result    (result),
        .carry_out (carry_out)
    );

    task automatic apply(input logic [WIDTH-1:0] av, input logic [WIDTH-1:0] bv,
                         input logic cv, input logic [1:0] ov);
        @(negedge clk);
        a = av; b = bv; carry_in = cv; op = ov;
        #2;
    endtask

    function automatic logic [WIDTH-1:0] model_result(input logic [WIDTH-1:0] av,
            input logic [WIDTH-1:0] bv, input logic cv, input logic [1:0] ov);
        logic [WIDTH:0] s;
        s = {1'b0, av} + {1'b0, bv} + {{WIDTH{1'b0}}, cv};
        case (ov)
            2'b00:   return av & bv;
            2'b01:   return av | bv;
            2'b10:   return av ^ bv;
            default: return s[WIDTH-1:0];
        endcase
    endfunction

    function automatic logic model_carry(input logic [WIDTH-1:0] av,
            input logic [WIDTH-1:0] bv, input logic cv);
        logic [WIDTH:0] s;
        s = {1'b0, av} + {1'b0, bv} + {{WIDTH{1'b0}}, cv};
        return s[WIDTH];
    endfunction

    task automatic expect_res(input string req, input logic [WIDTH-1:0] exp_r);
        checks++;
        if (result !== exp_r) begin
            errors++;
            $display("FAIL %s result actual=%h expected=%h", req, result, exp_r);
        end
    endtask

    task automatic expect_cout(input string req, input logic exp_c);
        checks++;
        if (carry_out !== exp_c) begin
            errors++;
            $display("FAIL %s carry_out actual=%0b expected=%0b", req, carry_out, exp_c);
        end
    endtask

    task automatic run_case(input string req, input logic [WIDTH-1:0] av,
                            input logic [WIDTH-1:0] bv, input logic cv, input logic [1:0] ov);
        apply(av, bv, cv, ov);
        expect_res(req, model_result(av, bv, cv, ov));
        expect_cout("R5", model_carry(av, bv, cv));
    endtask

    task automatic t_idle_state;
        apply('0, '0, 1'b0, 2'b00);
        expect_res("R1 idle", '0);
        expect_cout("R5 idle", 1'b0);
    endtask

    task automatic t_single_slice_example;
        apply(32'h1, 32'h1, 1'b0, 2'b00);
        expect_res("R8 and", 32'h1);
        apply(32'h1, 32'h1, 1'b0, 2'b10);
        expect_res("R8 xor", 32'h0);
        apply(32'h1, 32'h1, 1'b0, 2'b11);
        expect_res("R8 sum", 32'h2);
        checks++;
        if (result[0] !== 1'b0 || result[1] !== 1'b1) begin
            errors++;
            $display("FAIL R8 slice0 sum/carry actual=%0b%0b expected=10", result[1], result[0]);
        end
    endtask

    task automatic t_logic_ops;
        run_case("R1", 32'hF0F0_A5A5, 32'h0FF0_3C3C, 1'b0, 2'b00);
        run_case("R2", 32'hF0F0_A5A5, 32'h0FF0_3C3C, 1'b1, 2'b01);
        run_case("R3", 32'hF0F0_A5A5, 32'h0FF0_3C3C, 1'b0, 2'b10);
        for (int i = 0; i < 40; i++) begin
            run_case("R1", $urandom, $urandom, 1'($urandom), 2'b00);
            run_case("R2", $urandom, $urandom, 1'($urandom), 2'b01);
            run_case("R3", $urandom, $urandom, 1'($urandom), 2'b10);
        end
    endtask

    task automatic t_sum;
        run_case("R4", 32'h0000_0005, 32'h0000_0003, 1'b1, 2'b11);
        run_case("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b11);
        run_case("R4", 32'h8000_0000, 32'h8000_0000, 1'b0, 2'b11);
        for (int i = 0; i < 60; i++)
            run_case("R4", $urandom, $urandom, 1'($urandom), 2'b11);
    endtask

    task automatic t_full_ripple;
        apply('1, '0, 1'b1, 2'b11);
        expect_res("R6", '0);
        expect_cout("R6", 1'b1);
    endtask

    task automatic t_cin_ignored;
        for (int o = 0; o < 3; o++) begin
            logic [WIDTH-1:0] r0;
            apply(32'h1234_CDEF, 32'hFEDC_3210, 1'b0, 2'(o));
            r0 = result;
            apply(32'h1234_CDEF, 32'hFEDC_3210, 1'b1, 2'(o));
            checks++;
            if (result !== r0) begin
                errors++;
                $display("FAIL R7 op=%0d actual=%h expected=%h", o, result, r0);
            end
        end
    endtask

    task automatic t_carry_every_op;
        for (int o = 0; o < 4; o++) begin
            apply(32'hFFFF_0000, 32'h0001_0000, 1'b0, 2'(o));
            expect_cout("R5 all ops", 1'b1);
            apply(32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 2'(o));
            expect_cout("R5 all ops", 1'b0);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle_state();
        t_single_slice_example();
        t_logic_ops();
        t_sum();
        t_full_ripple();
        t_cin_ignored();
        t_carry_every_op();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule